// File: doc/BRIEF.md
# Keyed Indexed Configuration Port

This block gives a host an 8-bit configuration path through two adjacent I/O addresses. The lower address is the index port and the address above it is the data port. After reset the port is locked. A fixed key must be written twice in a row to the index port before any register becomes visible. Once the port is open, the host writes a register number to the index port and then reads or writes that register through the data port. Writing the exit key to the index port locks the port again.

Register numbers below a boundary are global. The block holds these registers itself: the logical-device selector and a two-byte chip identifier. Register numbers at or above the boundary belong to whichever logical device the selector names. Accesses to them are passed on as single-cycle read or write strobes, and each strobe carries the device number, the register number and the write data. Read data from the device returns in the same cycle. A strap input chooses which of two base addresses the port answers on.

Top module: `cfg_index_port`

## Requirements
- R1: The port opens only after two index-port writes of 0x87 with no port write between them. Before that, data-port reads return 0xFF.
- R2: Once the first 0x87 has been written, any other port write (index or data) sends the key sequence back to its start, so two further 0x87 writes are needed.
- R3: While the port is open, an index-port write of 0xAA locks it. Data-port reads then return 0xFF.
- R4: The index port sits at base+0 and the data port at base+1. The base is 0x2E when strap_hi_i=0 and 0x4E when strap_hi_i=1. Accesses to any other address have no effect, and a read of such an address returns 0xFF.
- R5: Global register 0x07 is read/write and resets to 0x00. It holds the selected logical device number, which appears on dev_num_o.
- R6: Register 0x20 reads 0xA2 and register 0x21 reads 0x31. The upper 12 bits of the ID are 0xA23 and the revision is 1. Writes to both registers are ignored.
- R7: With index ≥ 0x30, a data-port write drives dev_wr_o for that bus cycle only, with dev_num_o, dev_reg_o and dev_wdata_o valid. A data-port read drives dev_rd_o and returns dev_rdata_i on io_rdata_o in the same cycle.
- R8: While the port is locked, data-port writes change no register and raise no strobe, and index-port reads return 0xFF.
- R9: While the port is open, an index-port read returns the current index. Any other global register below 0x30 reads 0x00 and ignores writes.
- R10: After reset the port is locked and both the index and the selector are 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_hi_i | input | 1 | Base select: 0 gives 0x2E, 1 gives 0x4E |
| io_addr_i | input | 16 | Host I/O address |
| io_wr_i | input | 1 | Host write cycle |
| io_rd_i | input | 1 | Host read cycle |
| io_wdata_i | input | 8 | Host write data |
| io_rdata_o | output | 8 | Host read data, valid in the read cycle |
| dev_wr_o | output | 1 | Banked register write strobe |
| dev_rd_o | output | 1 | Banked register read strobe |
| dev_num_o | output | 8 | Selected logical device number |
| dev_reg_o | output | 8 | Banked register number |
| dev_wdata_o | output | 8 | Banked write data |
| dev_rdata_i | input | 8 | Read data returned by the addressed device |

## Verification
The assertions assume that io_wr_i and io_rd_i are never high in the same cycle. They also assume that each host access lasts exactly one clock, so a strobe lasts one cycle. They assume strap_hi_i changes only while the bus is idle. The bench drives every access through a single write task or a single read task. Each task raises exactly one command for one cycle, on the falling edge, and leaves the bus idle between accesses. The strap input is changed only between tasks.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_KEY1   = 2'd1,
    KS_OPEN   = 2'd2
  } key_state_e;

  localparam logic [7:0] DEF_KEY_ENTER = 8'h87;
  localparam logic [7:0] DEF_KEY_EXIT  = 8'hAA;
  localparam logic [7:0] DEF_LDN_REG   = 8'h07;
  localparam logic [7:0] DEF_ID_HI_REG = 8'h20;
  localparam logic [7:0] DEF_ID_LO_REG = 8'h21;
  localparam logic [7:0] DEF_BANK_LO   = 8'h30;
  localparam logic [7:0] LOCKED_RDATA  = 8'hFF;
endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode #(
  parameter int unsigned       ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] BASE_LO = 16'h002E,
  parameter logic [ADDR_W-1:0] BASE_HI = 16'h004E
) (
  input  logic              strap_hi_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              idx_sel_o,
  output logic              dat_sel_o
);
  logic [ADDR_W-1:0] base;

  assign base      = strap_hi_i ? BASE_HI : BASE_LO;
  assign idx_sel_o = (addr_i == base);
  assign dat_sel_o = (addr_i == base + ADDR_W'(1));
endmodule

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm
  import cfg_port_pkg::*;
#(
  parameter logic [7:0] KEY_ENTER = DEF_KEY_ENTER,
  parameter logic [7:0] KEY_EXIT  = DEF_KEY_EXIT
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       idx_wr_i,
  input  logic       dat_wr_i,
  input  logic [7:0] wdata_i,
  output logic       unlocked_o
);
  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      KS_LOCKED: if (idx_wr_i && wdata_i == KEY_ENTER) state_d = KS_KEY1;
      KS_KEY1: begin
        if (idx_wr_i && wdata_i == KEY_ENTER) state_d = KS_OPEN;
        else if (idx_wr_i || dat_wr_i)        state_d = KS_LOCKED;
      end
      KS_OPEN:   if (idx_wr_i && wdata_i == KEY_EXIT) state_d = KS_LOCKED;
      default:   state_d = KS_LOCKED;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= KS_LOCKED;
    else         state_q <= state_d;
  end

  assign unlocked_o = (state_q == KS_OPEN);
endmodule

// File: rtl/cfg_reg_window.sv
module cfg_reg_window
  import cfg_port_pkg::*;
#(
  parameter logic [15:0] CHIP_ID   = 16'hA231,
  parameter logic [7:0]  KEY_EXIT  = DEF_KEY_EXIT,
  parameter logic [7:0]  LDN_REG   = DEF_LDN_REG,
  parameter logic [7:0]  ID_HI_REG = DEF_ID_HI_REG,
  parameter logic [7:0]  ID_LO_REG = DEF_ID_LO_REG,
  parameter logic [7:0]  BANK_LO   = DEF_BANK_LO
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       unlocked_i,
  input  logic       idx_sel_i,
  input  logic       dat_sel_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic [7:0] index_o,
  output logic       dev_wr_o,
  output logic       dev_rd_o,
  output logic [7:0] dev_num_o,
  output logic [7:0] dev_reg_o,
  output logic [7:0] dev_wdata_o,
  input  logic [7:0] dev_rdata_i
);
  logic [7:0] index_q, ldn_q;
  logic       banked, idx_wr, ldn_wr;
  logic [7:0] glob_rdata;

  assign banked = (index_q >= BANK_LO);
  assign idx_wr = unlocked_i && wr_i && idx_sel_i && (wdata_i != KEY_EXIT);
  assign ldn_wr = unlocked_i && wr_i && dat_sel_i && (index_q == LDN_REG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      index_q <= '0;
      ldn_q   <= '0;
    end else begin
      if (idx_wr) index_q <= wdata_i;
      if (ldn_wr) ldn_q   <= wdata_i;
    end
  end

  always_comb begin
    glob_rdata = 8'h00;
    if (index_q == LDN_REG)        glob_rdata = ldn_q;
    else if (index_q == ID_HI_REG) glob_rdata = CHIP_ID[15:8];
    else if (index_q == ID_LO_REG) glob_rdata = CHIP_ID[7:0];
  end

  always_comb begin
    rdata_o = LOCKED_RDATA;
    if (unlocked_i && rd_i) begin
      if (idx_sel_i)      rdata_o = index_q;
      else if (dat_sel_i) rdata_o = banked ? dev_rdata_i : glob_rdata;
    end
  end

  assign dev_wr_o    = unlocked_i && wr_i && dat_sel_i && banked;
  assign dev_rd_o    = unlocked_i && rd_i && dat_sel_i && banked;
  assign dev_num_o   = ldn_q;
  assign dev_reg_o   = index_q;
  assign dev_wdata_o = wdata_i;
  assign index_o     = index_q;
endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
  import cfg_port_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_LO   = 16'h002E,
  parameter logic [ADDR_W-1:0] BASE_HI   = 16'h004E,
  parameter logic [15:0]       CHIP_ID   = 16'hA231,
  parameter logic [7:0]        KEY_ENTER = DEF_KEY_ENTER,
  parameter logic [7:0]        KEY_EXIT  = DEF_KEY_EXIT,
  parameter logic [7:0]        LDN_REG   = DEF_LDN_REG,
  parameter logic [7:0]        ID_HI_REG = DEF_ID_HI_REG,
  parameter logic [7:0]        ID_LO_REG = DEF_ID_LO_REG,
  parameter logic [7:0]        BANK_LO   = DEF_BANK_LO
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strap_hi_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  input  logic [7:0]        io_wdata_i,
  output logic [7:0]        io_rdata_o,
  output logic              dev_wr_o,
  output logic              dev_rd_o,
  output logic [7:0]        dev_num_o,
  output logic [7:0]        dev_reg_o,
  output logic [7:0]        dev_wdata_o,
  input  logic [7:0]        dev_rdata_i
);
  logic idx_sel, dat_sel, unlocked;
  logic [7:0] index_q;

  cfg_addr_decode #(
    .ADDR_W (ADDR_W),
    .BASE_LO(BASE_LO),
    .BASE_HI(BASE_HI)
  ) i_decode (
    .strap_hi_i(strap_hi_i),
    .addr_i    (io_addr_i),
    .idx_sel_o (idx_sel),
    .dat_sel_o (dat_sel)
  );

  cfg_key_fsm #(
    .KEY_ENTER(KEY_ENTER),
    .KEY_EXIT (KEY_EXIT)
  ) i_key (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .idx_wr_i  (io_wr_i && idx_sel),
    .dat_wr_i  (io_wr_i && dat_sel),
    .wdata_i   (io_wdata_i),
    .unlocked_o(unlocked)
  );

  cfg_reg_window #(
    .CHIP_ID  (CHIP_ID),
    .KEY_EXIT (KEY_EXIT),
    .LDN_REG  (LDN_REG),
    .ID_HI_REG(ID_HI_REG),
    .ID_LO_REG(ID_LO_REG),
    .BANK_LO  (BANK_LO)
  ) i_window (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .unlocked_i (unlocked),
    .idx_sel_i  (idx_sel),
    .dat_sel_i  (dat_sel),
    .wr_i       (io_wr_i),
    .rd_i       (io_rd_i),
    .wdata_i    (io_wdata_i),
    .rdata_o    (io_rdata_o),
    .index_o    (index_q),
    .dev_wr_o   (dev_wr_o),
    .dev_rd_o   (dev_rd_o),
    .dev_num_o  (dev_num_o),
    .dev_reg_o  (dev_reg_o),
    .dev_wdata_o(dev_wdata_o),
    .dev_rdata_i(dev_rdata_i)
  );
endmodule

// File: rtl/cfg_index_port_chk.sv
module cfg_index_port_chk #(
  parameter int unsigned       ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_LO   = 16'h002E,
  parameter logic [ADDR_W-1:0] BASE_HI   = 16'h004E,
  parameter logic [15:0]       CHIP_ID   = 16'hA231,
  parameter logic [7:0]        KEY_ENTER = 8'h87,
  parameter logic [7:0]        KEY_EXIT  = 8'hAA,
  parameter logic [7:0]        ID_HI_REG = 8'h20,
  parameter logic [7:0]        BANK_LO   = 8'h30
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              strap_hi_i,
  input logic [ADDR_W-1:0] io_addr_i,
  input logic              io_wr_i,
  input logic              io_rd_i,
  input logic [7:0]        io_wdata_i,
  input logic [7:0]        io_rdata_o,
  input logic              dev_wr_o,
  input logic              dev_rd_o,
  input logic [7:0]        dev_reg_o,
  input logic              unlocked_i,
  input logic [7:0]        index_i
);
  logic [ADDR_W-1:0] base;
  logic idx_hit, dat_hit;
  assign base    = strap_hi_i ? BASE_HI : BASE_LO;
  assign idx_hit = (io_addr_i == base);
  assign dat_hit = (io_addr_i == base + ADDR_W'(1));

  AST_OPEN_NEEDS_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unlocked_i) |-> $past(io_wr_i && io_wdata_i == KEY_ENTER)); // R1

  AST_EXIT_RELOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unlocked_i && io_wr_i && idx_hit && io_wdata_i == KEY_EXIT) |=> !unlocked_i); // R3

  AST_MISS_READS_FF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rd_i && !idx_hit && !dat_hit) |-> io_rdata_o == 8'hFF); // R4

  AST_ID_HI_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unlocked_i && io_rd_i && dat_hit && index_i == ID_HI_REG)
      |-> io_rdata_o == CHIP_ID[15:8]); // R6

  AST_STROBE_BANKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_wr_o || dev_rd_o) |-> (dev_reg_o >= BANK_LO && dat_hit)); // R7

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dev_wr_o, dev_rd_o})); // R7

  AST_LOCKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlocked_i |-> (!dev_wr_o && !dev_rd_o)); // R8
endmodule

bind cfg_index_port cfg_index_port_chk #(
  .ADDR_W   (ADDR_W),
  .BASE_LO  (BASE_LO),
  .BASE_HI  (BASE_HI),
  .CHIP_ID  (CHIP_ID),
  .KEY_ENTER(KEY_ENTER),
  .KEY_EXIT (KEY_EXIT),
  .ID_HI_REG(ID_HI_REG),
  .BANK_LO  (BANK_LO)
) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .strap_hi_i(strap_hi_i),
  .io_addr_i (io_addr_i),
  .io_wr_i   (io_wr_i),
  .io_rd_i   (io_rd_i),
  .io_wdata_i(io_wdata_i),
  .io_rdata_o(io_rdata_o),
  .dev_wr_o  (dev_wr_o),
  .dev_rd_o  (dev_rd_o),
  .dev_reg_o (dev_reg_o),
  .unlocked_i(unlocked),
  .index_i   (index_q)
);

// File: tb/test_cfg_index_port.sv
module test_cfg_index_port;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        strap_hi_i = 1'b0;
  logic [15:0] io_addr_i = '0;
  logic        io_wr_i = 1'b0;
  logic        io_rd_i = 1'b0;
  logic [7:0]  io_wdata_i = '0;
  logic [7:0]  io_rdata_o;
  logic        dev_wr_o, dev_rd_o;
  logic [7:0]  dev_num_o, dev_reg_o, dev_wdata_o;
  logic [7:0]  dev_rdata_i = '0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [15:0] base = 16'h002E;

  logic       s_wr, s_rd;
  logic [7:0] s_num, s_reg, s_wdata, s_rdata;

  cfg_index_port i_cfg_index_port (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk_i);
    io_addr_i = a; io_wdata_i = d; io_wr_i = 1'b1;
    #(CLK_PERIOD/5);
    s_wr = dev_wr_o; s_rd = dev_rd_o;
    s_num = dev_num_o; s_reg = dev_reg_o; s_wdata = dev_wdata_o;
    @(negedge clk_i);
    io_wr_i = 1'b0;
  endtask

  task automatic bus_rd(logic [15:0] a);
    @(negedge clk_i);
    io_addr_i = a; io_rd_i = 1'b1;
    #(CLK_PERIOD/5);
    s_rdata = io_rdata_o; s_wr = dev_wr_o; s_rd = dev_rd_o;
    @(negedge clk_i);
    io_rd_i = 1'b0;
  endtask

  task automatic unlock();
    bus_wr(base, 8'h87);
    bus_wr(base, 8'h87);
  endtask

  task automatic reg_rd(logic [7:0] r);
    bus_wr(base, r);
    bus_rd(base + 16'd1);
  endtask

  task automatic t_reset();
    bus_rd(base + 16'd1);
    chk("R10 locked data read", s_rdata, 8'hFF);
    bus_rd(base);
    chk("R8 locked index read", s_rdata, 8'hFF);
  endtask

  task automatic t_unlock_id();
    bus_wr(base, 8'h87);
    bus_rd(base + 16'd1);
    chk("R1 one key only", s_rdata, 8'hFF);
    bus_wr(base, 8'h87);
    bus_rd(base);
    chk("R10 index after reset", s_rdata, 8'h00);
    reg_rd(8'h07);
    chk("R10 selector after reset", s_rdata, 8'h00);
    reg_rd(8'h20);
    chk("R1 open after two keys, id hi", s_rdata, 8'hA2);
    reg_rd(8'h21);
    chk("R6 id lo", s_rdata, 8'h31);
  endtask

  task automatic t_ldn_bank();
    bus_wr(base, 8'h07);
    bus_wr(base + 16'd1, 8'h05);
    bus_rd(base + 16'd1);
    chk("R5 selector readback", s_rdata, 8'h05);
    bus_wr(base, 8'h30);
    bus_wr(base + 16'd1, 8'h3C);
    chk("R7 wr strobe", {7'd0, s_wr}, 8'h01);
    chk("R7 wr dev num", s_num, 8'h05);
    chk("R7 wr reg", s_reg, 8'h30);
    chk("R7 wr data", s_wdata, 8'h3C);
    chk("R7 no rd on wr", {7'd0, s_rd}, 8'h00);
    @(negedge clk_i);
    chk("R7 wr strobe one cycle", {7'd0, dev_wr_o}, 8'h00);
    dev_rdata_i = 8'h5A;
    bus_wr(base, 8'hE5);
    bus_rd(base + 16'd1);
    chk("R7 rd strobe", {7'd0, s_rd}, 8'h01);
    chk("R7 rd data", s_rdata, 8'h5A);
  endtask

  task automatic t_global_ro();
    bus_wr(base, 8'h20);
    bus_wr(base + 16'd1, 8'h00);
    chk("R6 id write no strobe", {7'd0, s_wr}, 8'h00);
    bus_rd(base + 16'd1);
    chk("R6 id ignores write", s_rdata, 8'hA2);
    bus_wr(base, 8'h25);
    bus_wr(base + 16'd1, 8'h77);
    bus_rd(base + 16'd1);
    chk("R9 spare global reads zero", s_rdata, 8'h00);
    bus_rd(base);
    chk("R9 index readback", s_rdata, 8'h25);
  endtask

  task automatic t_exit_locked();
    bus_wr(base, 8'h07);
    bus_wr(base, 8'hAA);
    bus_rd(base + 16'd1);
    chk("R3 relocked read", s_rdata, 8'hFF);
    bus_wr(base + 16'd1, 8'h99);
    chk("R8 locked write no strobe", {7'd0, s_wr}, 8'h00);
    unlock();
    bus_rd(base);
    chk("R3 exit key not stored as index", s_rdata, 8'h07);
    bus_rd(base + 16'd1);
    chk("R8 selector untouched while locked", s_rdata, 8'h05);
    bus_wr(base, 8'hAA);
  endtask

  task automatic t_broken_key();
    bus_wr(base, 8'h87);
    bus_wr(base + 16'd1, 8'h00);
    bus_wr(base, 8'h87);
    bus_rd(base + 16'd1);
    chk("R2 data write breaks key", s_rdata, 8'hFF);
    bus_wr(base, 8'h87);
    reg_rd(8'h20);
    chk("R2 fresh pair opens", s_rdata, 8'hA2);
    bus_wr(base, 8'hAA);
    bus_wr(base, 8'h87);
    bus_wr(base, 8'h11);
    bus_wr(base, 8'h87);
    bus_rd(base + 16'd1);
    chk("R2 index write breaks key", s_rdata, 8'hFF);
    bus_wr(base, 8'h87);
    bus_wr(base, 8'hAA);
  endtask

  task automatic t_strap();
    strap_hi_i = 1'b1;
    base = 16'h004E;
    bus_rd(16'h002F);
    chk("R4 old base miss", s_rdata, 8'hFF);
    unlock();
    bus_wr(16'h002E, 8'hAA);
    reg_rd(8'h20);
    chk("R4 high base, old address ignored", s_rdata, 8'hA2);
    bus_rd(16'h0050);
    chk("R4 stray address reads FF", s_rdata, 8'hFF);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_unlock_id();
    t_ldn_bank();
    t_global_ro();
    t_exit_locked();
    t_broken_key();
    t_strap();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule